// File: doc/BRIEF.md
# Delimited Serial Octet Receiver with Busy Pacing

This block takes a bit-serial message stream made of three lines: a bit clock, a data line and a message delimiter. It samples all three in the system clock domain, finds the rising edges of the bit clock and shifts the data into octets. The delimiter is high for the length of a message. The bit on which it rises starts the first octet, and every eighth bit after that starts a new one. Each finished octet leaves on a valid/ready stream with tags for the first octet of a message, the last octet, and an overrun indicator.

The block drives a busy line back to the transmitter so that the link moves one octet at a time. Busy rises once the first bit of an octet has been sampled. It falls when the block has room for a whole further octet. After the delimiter drops, busy stays high until the downstream consumer has taken the last octet of the message. The block has to hold one finished octet back until it knows whether a further complete octet follows, because that is the only way it can tag the last octet.

Downstream back-pressure works as follows. A beat is offered with `rx_valid` high and moves on the clock edge where `rx_ready` is also high. While `rx_ready` stays low, the beat and its tags stay unchanged. The consumer can stall as long as it likes. Its stalls reach the transmitter only through busy.

Top module: `delim_serial_rx`

## Requirements
- R1: After reset, `link_busy`, `rx_valid` and `frame_err` are low.
- R2: Bits are sampled on rising edges of `link_clk`. The first octet of a message starts on the sample where `link_delim` rises, and each later octet starts eight samples after the one before it. The first bit of each octet is the most significant bit of `rx_data`.
- R3: `rx_first` is 1 only on the first beat of a message, and `rx_last` is 1 only on its final complete octet. A one-octet message carries both. Every complete octet is delivered exactly once, in order.
- R4: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and the tags hold their values.
- R5: `link_busy` is high once the first bit of an octet has been taken in, and it stays high through that octet. It is low at an octet boundary whenever the output register is free to take another octet.
- R6: Once the delimiter has been sampled low after a message that holds at least one complete octet, `link_busy` stays high until the last beat of that message has been accepted downstream. It then falls within a few clocks.
- R7: A bit sampled at an octet boundary while `link_busy` is high for a full output is discarded. The message's last beat then carries `rx_overrun` = 1. Octets that were already complete are still delivered.
- R8: A message whose delimiter rise follows fewer than `GAP_BITS` low-delimiter samples pulses `frame_err` for one clock. A gap of exactly `GAP_BITS` samples does not. Either way the message is still received.
- R9: If the delimiter falls partway through an octet, the partial bits are dropped and `frame_err` pulses once. The last complete octet is still delivered with `rx_last` = 1.
- R10: `rx_overrun` is cleared at each new message, so a message without overrun ends with `rx_overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk | input | 1 | Serial bit clock from the transmitter |
| link_data | input | 1 | Serial data line |
| link_delim | input | 1 | Message delimiter, high during a message |
| link_busy | output | 1 | Pacing signal to the transmitter |
| rx_data | output | 8 | Received octet |
| rx_first | output | 1 | Beat is the first octet of a message |
| rx_last | output | 1 | Beat is the last octet of a message |
| rx_overrun | output | 1 | On the last beat: bits were lost in this message |
| rx_valid | output | 1 | Output beat valid |
| rx_ready | input | 1 | Downstream accepts the beat |
| frame_err | output | 1 | One-clock pulse on a short gap or a partial trailing octet |

## Verification
The bench builds the block with its defaults: `GAP_BITS` = 8 and `SYNC_STAGES` = 2. The link half-period is four system clocks. These values let gaps of 3, 7 and 8 bit periods probe both sides of the gap threshold within a short run. The two-stage synchroniser keeps the busy reaction a few clocks long, so the bench can watch busy in the middle of the first bit. Holding `rx_ready` low while the transmitter ignores busy produces an overrun that can be forced on purpose. Random messages with random downstream stalls then check ordering and tagging under back-pressure.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int OCTET_W = 8;
  localparam int CNT_W   = $clog2(OCTET_W);

  typedef struct packed {
    logic [OCTET_W-1:0] data;
    logic               first;
    logic               last;
    logic               ovr;
  } beat_t;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsr_bitfront.sv
module dsr_bitfront #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_clk,
  input  logic link_data,
  input  logic link_delim,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_delim
);
  logic [2:0] line_s;
  logic       sclk_q;

  dsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({link_clk, link_data, link_delim}),
    .q    (line_s)
  );

  // remember the synchronised bit clock to find its rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= line_s[2];
  end

  assign bit_stb   = line_s[2] & ~sclk_q;
  assign bit_val   = line_s[1];
  assign bit_delim = line_s[0];

  // one strobe per link clock rise (R2)
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/dsr_framer.sv
module dsr_framer
  import dsr_pkg::*;
#(
  parameter int GAP_BITS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_stb,
  input  logic  bit_val,
  input  logic  bit_delim,
  input  logic  out_full,
  input  logic  out_done,
  output logic  push_valid,
  output beat_t push_beat,
  output logic  busy,
  output logic  frame_err
);
  localparam int GW = $clog2(GAP_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OCTET_W - 1);

  logic               in_msg, ending, prev_delim;
  logic [GW-1:0]      gap_cnt;
  logic [CNT_W-1:0]   bit_cnt;
  logic [OCTET_W-2:0] shreg;
  logic               hold_full, hold_first, first_next, ovr_flag;
  logic [OCTET_W-1:0] hold_data;

  logic live_bit, start, stall, ovr_bit, take, end_det, octet_done;
  logic push_mid, push_end;

  always_comb begin
    live_bit   = bit_stb & bit_delim;
    start      = live_bit & ~prev_delim & ~in_msg & ~ending;
    stall      = hold_full & out_full;
    ovr_bit    = live_bit & in_msg & (bit_cnt == '0) & stall;
    take       = live_bit & in_msg & ~ovr_bit;
    end_det    = bit_stb & ~bit_delim & in_msg;
    octet_done = take & (bit_cnt == LAST_BIT);
    // held octet is known not-last once the next one completes
    push_mid   = octet_done & hold_full;
    push_end   = ending & hold_full & ~out_full;
    push_valid = push_mid | push_end;
    push_beat  = '{data: hold_data, first: hold_first,
                   last: push_end, ovr: push_end & ovr_flag};
    busy       = (bit_cnt != '0) | stall | ending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg     <= 1'b0;
      ending     <= 1'b0;
      prev_delim <= 1'b0;
      gap_cnt    <= GW'(GAP_BITS);
      bit_cnt    <= '0;
      shreg      <= '0;
      hold_full  <= 1'b0;
      hold_first <= 1'b0;
      hold_data  <= '0;
      first_next <= 1'b0;
      ovr_flag   <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      frame_err <= 1'b0;

      if (bit_stb) begin
        prev_delim <= bit_delim;
        if (bit_delim)                    gap_cnt <= '0;
        else if (gap_cnt < GW'(GAP_BITS)) gap_cnt <= gap_cnt + 1'b1;
      end

      if (start) begin
        in_msg     <= 1'b1;
        first_next <= 1'b1;
        ovr_flag   <= 1'b0;
        bit_cnt    <= CNT_W'(1);
        shreg      <= {shreg[OCTET_W-3:0], bit_val};
        frame_err  <= (gap_cnt < GW'(GAP_BITS));
      end else if (take) begin
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        shreg   <= {shreg[OCTET_W-3:0], bit_val};
        if (octet_done) begin
          hold_data  <= {shreg, bit_val};
          hold_full  <= 1'b1;
          hold_first <= first_next;
          first_next <= 1'b0;
        end
      end

      if (ovr_bit) ovr_flag <= 1'b1;

      if (end_det) begin
        in_msg    <= 1'b0;
        bit_cnt   <= '0;
        frame_err <= (bit_cnt != '0);
        ending    <= hold_full;
      end

      if (push_end) hold_full <= 1'b0;
      if (ending && out_done) ending <= 1'b0;
    end
  end

  p_busy_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start || (take && bit_cnt == '0)) |=> busy);

  p_end_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_det && hold_full) |=> busy);

  p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !out_full);

  p_ovr_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_bit |=> (bit_cnt == '0) && ovr_flag);

  p_ferr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

// File: rtl/dsr_outreg.sv
module dsr_outreg
  import dsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_valid,
  input  beat_t push_beat,
  output logic  out_valid,
  input  logic  out_ready,
  output beat_t out_beat,
  output logic  last_taken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else if (push_valid) begin
      out_valid <= 1'b1;
      out_beat  <= push_beat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign last_taken = out_valid & out_ready & out_beat.last;

  p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_beat));
endmodule

// File: rtl/delim_serial_rx.sv
module delim_serial_rx
  import dsr_pkg::*;
#(
  parameter int GAP_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_clk,
  input  logic               link_data,
  input  logic               link_delim,
  output logic               link_busy,
  output logic [OCTET_W-1:0] rx_data,
  output logic               rx_first,
  output logic               rx_last,
  output logic               rx_overrun,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic               frame_err
);
  logic  bit_stb, bit_val, bit_delim;
  logic  push_valid, last_taken;
  beat_t push_beat, out_beat;

  dsr_bitfront #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_clk  (link_clk),
    .link_data (link_data),
    .link_delim(link_delim),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .bit_delim (bit_delim)
  );

  dsr_framer #(.GAP_BITS(GAP_BITS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .bit_delim (bit_delim),
    .out_full  (rx_valid),
    .out_done  (last_taken),
    .push_valid(push_valid),
    .push_beat (push_beat),
    .busy      (link_busy),
    .frame_err (frame_err)
  );

  dsr_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(push_valid),
    .push_beat (push_beat),
    .out_valid (rx_valid),
    .out_ready (rx_ready),
    .out_beat  (out_beat),
    .last_taken(last_taken)
  );

  assign rx_data    = out_beat.data;
  assign rx_first   = out_beat.first;
  assign rx_last    = out_beat.last;
  assign rx_overrun = out_beat.ovr;
endmodule

// File: tb/tb_delim_serial_rx.sv
`timescale 1ns/1ps
module tb_delim_serial_rx;
  localparam int GAP = 8;
  localparam int HB  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_clk = 1'b0, link_data = 1'b0, link_delim = 1'b0;
  logic link_busy, rx_first, rx_last, rx_overrun, rx_valid, frame_err;
  logic rx_ready;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  delim_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_data(link_data),
    .link_delim(link_delim), .link_busy(link_busy), .rx_data(rx_data),
    .rx_first(rx_first), .rx_last(rx_last), .rx_overrun(rx_overrun),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .frame_err(frame_err)
  );

  int n_chk = 0, n_fail = 0;
  int ready_mode = 0;
  int ferr_cnt = 0;
  int e_wr = 0, got = 0;
  bit finished = 0;
  logic [7:0] e_data [0:511];
  bit e_first [0:511];
  bit e_last  [0:511];
  bit e_ovr   [0:511];
  logic [7:0] msg_buf [0:7];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_push(input logic [7:0] d, input bit f,
                                   input bit l, input bit o);
    e_data[e_wr] = d; e_first[e_wr] = f; e_last[e_wr] = l; e_ovr[e_wr] = o;
    e_wr++;
  endfunction

  // downstream model and scoreboard
  always @(negedge clk) begin
    case (ready_mode)
      0:       rx_ready = 1'b0;
      1:       rx_ready = 1'b1;
      default: rx_ready = 1'($urandom_range(0, 1));
    endcase
    if (rst_n && frame_err) ferr_cnt++;
    if (rst_n && rx_valid && rx_ready) begin
      if (got >= e_wr) begin
        chk(0, "R3", "unexpected beat", got, e_wr);
      end else begin
        chk(rx_data == e_data[got], "R2", "octet value", rx_data, e_data[got]);
        chk(rx_first == e_first[got], "R3", "first tag", rx_first, e_first[got]);
        chk(rx_last == e_last[got], "R3", "last tag", rx_last, e_last[got]);
        chk(rx_overrun == e_ovr[got], "R7/R10", "overrun tag", rx_overrun, e_ovr[got]);
      end
      got++;
    end
  end

  task automatic send_bit(input logic b, input logic d);
    @(negedge clk);
    link_data = b; link_delim = d;
    repeat (HB) @(negedge clk);
    link_clk = 1'b1;
    repeat (HB) @(negedge clk);
    link_clk = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (link_busy) @(negedge clk);
  endtask

  task automatic send_octet(input logic [7:0] v, input bit obey);
    if (obey) wait_idle();
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b1);
  endtask

  task automatic send_gap(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic send_msg(input int len, input int gap);
    for (int k = 0; k < len; k++) exp_push(msg_buf[k], k == 0, k == len - 1, 1'b0);
    for (int k = 0; k < len; k++) send_octet(msg_buf[k], 1'b1);
    send_gap(gap);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int f0;
    logic [7:0] held;
    void'($urandom(32'h5EED_0421));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(link_busy == 0, "R1", "busy in reset", link_busy, 0);
    chk(rx_valid == 0, "R1", "valid in reset", rx_valid, 0);
    chk(frame_err == 0, "R1", "frame_err in reset", frame_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(link_busy == 0, "R1", "busy after reset", link_busy, 0);

    // R2/R3: single-octet message
    ready_mode = 1;
    msg_buf[0] = 8'hA5;
    send_msg(1, GAP);

    // R5: busy rises on the first bit, falls when room exists
    exp_push(8'h96, 1, 0, 0);
    exp_push(8'h3B, 0, 1, 0);
    wait_idle();
    send_bit(1'b1, 1'b1);
    chk(link_busy == 1, "R5", "busy after first bit", link_busy, 1);
    for (int i = 6; i >= 0; i--) send_bit(1'(8'h96 >> i), 1'b1);
    repeat (2) @(negedge clk);
    chk(link_busy == 0, "R5", "busy at free boundary", link_busy, 0);
    send_octet(8'h3B, 1);
    send_gap(GAP);

    // R6/R4: end-of-message busy held by stalled downstream
    ready_mode = 0;
    msg_buf[0] = 8'hC4; msg_buf[1] = 8'h5D;
    send_msg(2, GAP);
    chk(link_busy == 1, "R6", "busy after delimiter fall", link_busy, 1);
    chk(rx_valid == 1, "R4", "beat offered", rx_valid, 1);
    held = rx_data;
    repeat (6) @(negedge clk);
    chk(rx_valid == 1 && rx_data == held, "R4", "beat held under stall", rx_data, held);
    chk(link_busy == 1, "R6", "busy still held", link_busy, 1);
    ready_mode = 1;
    repeat (10) @(negedge clk);
    chk(link_busy == 0, "R6", "busy released after hand-off", link_busy, 0);

    // R7: transmitter ignores busy while downstream stalls
    wait_idle();
    ready_mode = 0;
    exp_push(8'h11, 1, 0, 0);
    exp_push(8'h22, 0, 1, 1);
    send_octet(8'h11, 0);
    send_octet(8'h22, 0);
    send_octet(8'h33, 0);
    send_gap(GAP);
    ready_mode = 1;
    repeat (10) @(negedge clk);

    // R10: overrun cleared for the next message
    msg_buf[0] = 8'h7E; msg_buf[1] = 8'h81;
    send_msg(2, GAP);

    // R8: gap threshold
    f0 = ferr_cnt;
    msg_buf[0] = 8'h01; send_msg(1, 3);
    chk(ferr_cnt - f0 == 0, "R8", "no error after full gap", ferr_cnt - f0, 0);
    msg_buf[0] = 8'h02; send_msg(1, 7);
    chk(ferr_cnt - f0 == 1, "R8", "error after gap of 3", ferr_cnt - f0, 1);
    msg_buf[0] = 8'h03; send_msg(1, 8);
    chk(ferr_cnt - f0 == 2, "R8", "error after gap of 7", ferr_cnt - f0, 2);
    msg_buf[0] = 8'h04; send_msg(1, 8);
    chk(ferr_cnt - f0 == 2, "R8", "no error after gap of 8", ferr_cnt - f0, 2);

    // R9: trailing partial octet
    f0 = ferr_cnt;
    exp_push(8'h3C, 1, 1, 0);
    send_octet(8'h3C, 1);
    send_bit(1, 1); send_bit(0, 1); send_bit(1, 1); send_bit(0, 1);
    send_gap(GAP);
    chk(ferr_cnt - f0 == 1, "R9", "partial octet error", ferr_cnt - f0, 1);

    // random messages with random stalls
    ready_mode = 2;
    f0 = ferr_cnt;
    for (int m = 0; m < 40; m++) begin
      int len;
      len = int'($urandom_range(1, 5));
      for (int k = 0; k < len; k++) msg_buf[k] = 8'($urandom);
      send_msg(len, int'($urandom_range(GAP, GAP + 2)));
    end
    chk(ferr_cnt == f0, "R8", "no error in random traffic", ferr_cnt - f0, 0);

    ready_mode = 1;
    repeat (200) begin
      if (got == e_wr) break;
      @(negedge clk);
    end
    chk(got == e_wr, "R3", "beat count", got, e_wr);
    chk(link_busy == 0, "R6", "idle at end", link_busy, 0);

    finished = 1;
    report();
    $finish;
  end
endmodule